// File: doc/BRIEF.md
# Parallel PRBS word checker

This block checks a received pseudorandom bit stream several bits per clock. Every valid word is fed through an unrolled Fibonacci shift register in feed-forward form. The register is filled with the received bits themselves, so the checker locks onto the pattern without a seed. Each serial bit is compared with the XOR of the tapped register bits. Any mismatch shows up as a set bit in a per-word error mask.

The number of marked bits in each word is added to a saturating error counter. A lock flag rises after a run of clean words. It drops when a single word carries more marks than a run-time limit. Compile-time parameters set:
- the polynomial, given as a hex mask with the top term implied by the register width;
- the serial bit order within a word;
- whether the stream arrives complemented, as some standard patterns are sent.

Top module: `prbs_word_checker`

## Requirements
- R1: A synchronous active-high reset clears the tap register, the warm-up fill, the error mask, the error counter and the lock flag. All three outputs read zero at the first falling edge after a reset edge.
- R2: For a valid word, all three outputs (err_mask_o, err_cnt_o, lock_o) are registered at the same rising edge that captures that word. A stream that obeys the polynomial's recurrence gives an all-zero mask, counts nothing and never unlocks.
- R3: A single flipped bit at serial position p produces a mark at p and at p+d for each tap distance d. With the default x^7+x^6+1 this is three marks: at p, p+6 and p+7. The number of marks equals the number of terms of the full polynomial, counting the implied top term. Mask bit i always belongs to data bit i.
- R4: Marks from several flipped bits combine by XOR, so marks that land on the same serial position cancel.
- R5: Marks at serial positions below LFSR_W, counted in valid bits since reset, are discarded, because the register is not yet full of received bits.
- R6: A cycle with valid_i low shifts nothing. It clears err_mask_o at the next edge and leaves the counter and the lock flag unchanged, whatever data_i holds.
- R7: Each valid word adds the number of set bits in its mask to err_cnt_o. The counter saturates at 2^ERR_W-1.
- R8: lock_o rises at the edge of the LOCK_WORDS-th (default 16) consecutive valid word with no marks.
- R9: A valid word with more marks than unlock_limit_i clears lock_o. A word with marks that do not exceed the limit keeps lock_o but restarts the clean-word run.
- R10: With REVERSE=0 the serial order is MSB first (data bit DATA_W-1 first). With REVERSE=1 it is LSB first. With INVERT=1 every received bit is complemented before checking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Data word strobe |
| data_i | input | DATA_W | Received word |
| unlock_limit_i | input | $clog2(DATA_W+1) | Largest per-word mark count that keeps lock |
| err_mask_o | output | DATA_W | Marks for the last valid word, bit aligned with data_i |
| err_cnt_o | output | ERR_W | Saturating count of marked bits |
| lock_o | output | 1 | Pattern lock flag |

## Verification
All three results for a word are due one rising edge after the edge that captures it, and a bubble clears the mask one edge later. The bench therefore drives each word at a falling edge and samples every output at the next falling edge, before it drives the following word. Marks that spill into later words, up to seven serial positions on, are predicted in a bench-side error map and compared word by word. The lock checks count clean words exactly: the flag is checked low after the fifteenth clean word and high after the sixteenth.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int unsigned MAX_BITS = 64;

    typedef logic [MAX_BITS-1:0] wide_t;

    // population count of a zero-extended vector
    function automatic int unsigned ones(input wide_t v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAX_BITS; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    // XOR of the register bits the polynomial taps, top term implied by width w
    function automatic logic tap_xor(input wide_t st, input wide_t poly, input int unsigned w);
        logic fb;
        fb = st[w-1];
        for (int j = 1; j < MAX_BITS; j++) begin
            if (j < int'(w) && poly[j]) begin
                fb ^= st[j-1];
            end
        end
        return fb;
    endfunction

endpackage

// File: rtl/prbs_ff_stage.sv
module prbs_ff_stage #(
    parameter int unsigned LFSR_W  = 7,
    parameter logic [LFSR_W-1:0] POLY = 'h41,
    parameter int unsigned DATA_W  = 8,
    parameter bit          INVERT  = 1'b0,
    parameter bit          REVERSE = 1'b0
) (
    input  logic [LFSR_W-1:0] state_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [LFSR_W-1:0] state_o,
    output logic [DATA_W-1:0] smark_o   // marks in serial order, index 0 first
);
    import prbs_chk_pkg::*;

    logic [DATA_W-1:0] ser;

    // serial order picked by parameter, then optional complement
    for (genvar k = 0; k < DATA_W; k++) begin : g_ser
        if (REVERSE) begin : g_lsb
            assign ser[k] = data_i[k] ^ INVERT;
        end else begin : g_msb
            assign ser[k] = data_i[DATA_W-1-k] ^ INVERT;
        end
    end

    logic [LFSR_W-1:0] sh;

    always_comb begin
        sh = state_i;
        for (int k = 0; k < DATA_W; k++) begin
            smark_o[k] = ser[k] ^ tap_xor(wide_t'(sh), wide_t'(POLY), LFSR_W);
            sh = {sh[LFSR_W-2:0], ser[k]};
        end
        state_o = sh;
    end

endmodule

// File: rtl/prbs_warmup.sv
module prbs_warmup #(
    parameter int unsigned LFSR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] smark_i,
    output logic [DATA_W-1:0] qual_o
);
    localparam int unsigned FILL_W = $clog2(LFSR_W + 1);

    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_nxt;

    always_comb begin
        for (int k = 0; k < DATA_W; k++) begin
            qual_o[k] = smark_i[k] & ((int'(fill_q) + k) >= int'(LFSR_W));
        end
    end

    always_comb begin
        if (int'(fill_q) + int'(DATA_W) >= int'(LFSR_W)) begin
            fill_nxt = FILL_W'(LFSR_W);
        end else begin
            fill_nxt = fill_q + FILL_W'(DATA_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (valid_i) begin
            fill_nxt_apply: fill_q <= fill_nxt;
        end
    end

    // R5
    fill_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && int'(fill_q) < int'(LFSR_W)) |=> (fill_q > $past(fill_q)));

    // R5
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(fill_q));

endmodule

// File: rtl/prbs_err_tally.sv
module prbs_err_tally #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ERR_W      = 32,
    parameter int unsigned LOCK_WORDS = 16,
    localparam int unsigned NERR_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [NERR_W-1:0] nerr_i,
    input  logic [NERR_W-1:0] limit_i,
    output logic [ERR_W-1:0]  err_cnt_o,
    output logic              lock_o
);
    localparam int unsigned RUN_W = $clog2(LOCK_WORDS + 1);
    localparam int unsigned SUM_W = ERR_W + 1;
    localparam logic [ERR_W-1:0] CNT_MAX = '1;
    localparam logic [RUN_W-1:0] RUN_END = RUN_W'(LOCK_WORDS);

    logic [SUM_W-1:0] sum;
    logic [RUN_W-1:0] run_q;

    assign sum = {1'b0, err_cnt_o} + SUM_W'(nerr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cnt_o <= '0;
            run_q     <= '0;
            lock_o    <= 1'b0;
        end else if (valid_i) begin
            err_cnt_o <= sum[ERR_W] ? CNT_MAX : sum[ERR_W-1:0];
            if (nerr_i == '0) begin
                if (run_q != RUN_END) begin
                    run_q <= run_q + 1'b1;
                end
                if (run_q >= RUN_END - 1'b1) begin
                    lock_o <= 1'b1;
                end
            end else begin
                run_q <= '0;
                if (nerr_i > limit_i) begin
                    lock_o <= 1'b0;
                end
            end
        end
    end

    // R7
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_cnt_o >= $past(err_cnt_o)));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err_cnt_o - $past(err_cnt_o)) <= ERR_W'(DATA_W)));

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> ($past(valid_i) && $past(nerr_i) == '0));

    // R9
    unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && nerr_i > limit_i) |=> !lock_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(err_cnt_o) && $stable(lock_o)));

endmodule

// File: rtl/prbs_word_checker.sv
module prbs_word_checker #(
    parameter int unsigned LFSR_W     = 7,
    parameter logic [LFSR_W-1:0] POLY = 'h41,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ERR_W      = 32,
    parameter int unsigned LOCK_WORDS = 16,
    parameter bit          INVERT     = 1'b0,
    parameter bit          REVERSE    = 1'b0,
    localparam int unsigned NERR_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [NERR_W-1:0] unlock_limit_i,
    output logic [DATA_W-1:0] err_mask_o,
    output logic [ERR_W-1:0]  err_cnt_o,
    output logic              lock_o
);
    import prbs_chk_pkg::*;

    logic [LFSR_W-1:0] taps_q;
    logic [LFSR_W-1:0] taps_nxt;
    logic [DATA_W-1:0] smark;
    logic [DATA_W-1:0] qual;
    logic [DATA_W-1:0] mask_word;
    logic [NERR_W-1:0] nerr;

    prbs_ff_stage #(
        .LFSR_W (LFSR_W),
        .POLY   (POLY),
        .DATA_W (DATA_W),
        .INVERT (INVERT),
        .REVERSE(REVERSE)
    ) u_stage (
        .state_i(taps_q),
        .data_i (data_i),
        .state_o(taps_nxt),
        .smark_o(smark)
    );

    prbs_warmup #(
        .LFSR_W(LFSR_W),
        .DATA_W(DATA_W)
    ) u_warmup (
        .clk    (clk),
        .rst    (rst),
        .valid_i(valid_i),
        .smark_i(smark),
        .qual_o (qual)
    );

    // back from serial order to data bit positions
    for (genvar k = 0; k < DATA_W; k++) begin : g_align
        if (REVERSE) begin : g_lsb
            assign mask_word[k] = qual[k];
        end else begin : g_msb
            assign mask_word[DATA_W-1-k] = qual[k];
        end
    end

    assign nerr = NERR_W'(ones(wide_t'(qual)));

    prbs_err_tally #(
        .DATA_W    (DATA_W),
        .ERR_W     (ERR_W),
        .LOCK_WORDS(LOCK_WORDS)
    ) u_tally (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_i),
        .nerr_i   (nerr),
        .limit_i  (unlock_limit_i),
        .err_cnt_o(err_cnt_o),
        .lock_o   (lock_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q     <= '0;
            err_mask_o <= '0;
        end else begin
            err_mask_o <= valid_i ? mask_word : '0;
            if (valid_i) begin
                taps_q <= taps_nxt;
            end
        end
    end

    // R6
    mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (err_mask_o == '0));

    // R6
    taps_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(taps_q));

    // R7
    mask_vs_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && err_cnt_o != '1) |=> ((err_cnt_o - $past(err_cnt_o)) <= ERR_W'($countones(err_mask_o))));

endmodule

// File: tb/prbs_word_checker_bench.sv
module prbs_word_checker_bench;

    localparam int LW = 7;
    localparam int DW = 8;
    localparam int EW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vld = 1'b0;
    logic [DW-1:0] dat = '0;
    logic          vld_r = 1'b0;
    logic [DW-1:0] dat_r = '0;
    logic [3:0]    lim = 4'd8;
    logic [DW-1:0] mask, mask_r;
    logic [EW-1:0] cnt, cnt_r;
    logic          lock, lock_r;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    prbs_word_checker #(.LFSR_W(LW), .POLY(7'h41), .DATA_W(DW), .ERR_W(EW),
                        .LOCK_WORDS(16), .INVERT(1'b0), .REVERSE(1'b0)) u_prbs_word_checker (
        .clk(clk), .rst(rst), .valid_i(vld), .data_i(dat), .unlock_limit_i(lim),
        .err_mask_o(mask), .err_cnt_o(cnt), .lock_o(lock));

    prbs_word_checker #(.LFSR_W(LW), .POLY(7'h41), .DATA_W(DW), .ERR_W(EW),
                        .LOCK_WORDS(16), .INVERT(1'b1), .REVERSE(1'b1)) u_prbs_word_checker_rev (
        .clk(clk), .rst(rst), .valid_i(vld_r), .data_i(dat_r), .unlock_limit_i(lim),
        .err_mask_o(mask_r), .err_cnt_o(cnt_r), .lock_o(lock_r));

    always #10ns clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL R2 watchdog actual=%0d cycles expected=finish", cycles);
            summary();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference pattern x^7+x^6+1, serial bits written MSB first into a word
    logic [6:0] gst;
    logic       errv [0:511];

    task automatic gen_word(output logic [7:0] w);
        logic b;
        for (int k = 0; k < 8; k++) begin
            b = gst[6] ^ gst[5];
            gst = {gst[5:0], b};
            w[7-k] = b;
        end
    endtask

    // R3 rule: a flip at serial p marks p, p+6, p+7
    task automatic mark_flip(input int p);
        errv[p]   = errv[p] ^ 1'b1;
        errv[p+6] = errv[p+6] ^ 1'b1;
        errv[p+7] = errv[p+7] ^ 1'b1;
    endtask

    function automatic logic [7:0] exp_mask(input int w, input bit rev);
        logic [7:0] m;
        for (int k = 0; k < 8; k++) begin
            logic b;
            b = (w * 8 + k >= LW) && errv[w*8+k];   // R5 warm-up window
            if (rev) m[k] = b;
            else     m[7-k] = b;
        end
        return m;
    endfunction

    function automatic logic [7:0] bitrev(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic put(input logic v, input logic [7:0] d);
        vld = v; dat = d;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; vld = 1'b0; vld_r = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        gst = 7'h01;
        for (int i = 0; i < 512; i++) errv[i] = 1'b0;
    endtask

    typedef struct packed {
        logic [7:0] word;
        logic [7:0] flip;
        logic [7:0] total;
        logic [7:0] req;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{8'd4, 8'h80, 8'd3, 8'd3},   // R3 single flip, first serial bit
        '{8'd4, 8'h01, 8'd3, 8'd3},   // R3 single flip, marks spill into next word
        '{8'd4, 8'h81, 8'd4, 8'd4},   // R4 overlapping marks cancel
        '{8'd5, 8'h03, 8'd4, 8'd4},   // R4 adjacent flips
        '{8'd6, 8'h00, 8'd0, 8'd2},   // R2 clean run
        '{8'd3, 8'hFF, 8'd8, 8'd4},   // R4 whole word flipped
        '{8'd0, 8'h80, 8'd1, 8'd5}    // R5 flip inside warm-up
    };

    initial begin
        logic [7:0] g;
        logic [7:0] fl;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 mask", 32'(mask), 0);
        check("R1 count", 32'(cnt), 0);
        check("R1 lock", 32'(lock), 0);

        // table of flip patterns, MSB-first instance
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            lim = 4'd8;
            for (int w = 0; w < 12; w++) begin
                gen_word(g);
                fl = (w == int'(VECS[i].word)) ? VECS[i].flip : 8'h00;
                for (int k = 0; k < 8; k++) if (fl[7-k]) mark_flip(w * 8 + k);
                put(1'b1, g ^ fl);
                check($sformatf("R%0d mask vec%0d word%0d", VECS[i].req, i, w), 32'(mask), 32'(exp_mask(w, 1'b0)));
            end
            check($sformatf("R%0d count vec%0d", VECS[i].req, i), 32'(cnt), 32'(VECS[i].total));
            check("R2 lock stays low in short run", 32'(lock), 0);
        end

        // R8 / R9 lock behaviour, limit 1
        do_reset();
        lim = 4'd1;
        for (int w = 0; w < 15; w++) begin gen_word(g); put(1'b1, g); end
        check("R8 lock after 15 clean", 32'(lock), 0);
        gen_word(g); put(1'b1, g);
        check("R8 lock after 16 clean", 32'(lock), 1);
        gen_word(g); put(1'b1, g ^ 8'h01);        // one mark in this word
        check("R9 one mark within limit", 32'(mask), 32'h01);
        check("R9 lock kept", 32'(lock), 1);
        gen_word(g); put(1'b1, g);                // two spilled marks
        check("R9 two marks over limit", 32'(mask), 32'h06);
        check("R9 lock dropped", 32'(lock), 0);
        for (int w = 0; w < 15; w++) begin gen_word(g); put(1'b1, g); end
        check("R8 relock after 15", 32'(lock), 0);
        gen_word(g); put(1'b1, g);
        check("R8 relock after 16", 32'(lock), 1);
        check("R7 count after lock test", 32'(cnt), 3);

        // R6 bubbles with garbage data
        do_reset();
        for (int w = 0; w < 3; w++) begin gen_word(g); put(1'b1, g); end
        for (int b = 0; b < 4; b++) begin
            put(1'b0, 8'hFF);
            check("R6 mask in bubble", 32'(mask), 0);
            check("R6 count in bubble", 32'(cnt), 0);
        end
        for (int w = 0; w < 3; w++) begin
            gen_word(g); put(1'b1, g);
            check("R6 no shift during bubble", 32'(mask), 0);
        end
        check("R6 count after bubbles", 32'(cnt), 0);

        // R7 saturation: constant ones gives 1 mark then 8 per word
        do_reset();
        for (int w = 0; w < 50; w++) put(1'b1, 8'hFF);
        check("R7 count before saturation", 32'(cnt), 393);
        check("R7 mask all marked", 32'(mask), 32'hFF);
        for (int w = 0; w < 90; w++) put(1'b1, 8'hFF);
        check("R7 count saturated", 32'(cnt), 1023);

        // R1 reset after a dirty state
        do_reset();
        check("R1 count cleared", 32'(cnt), 0);
        check("R1 mask cleared", 32'(mask), 0);

        // R10 inverted, LSB-first instance
        for (int w = 0; w < 6; w++) begin
            gen_word(g);
            fl = (w == 4) ? 8'h01 : 8'h00;       // data bit 0 = serial k0, p=32
            if (w == 4) mark_flip(32);
            vld_r = 1'b1; dat_r = bitrev(~g) ^ fl;
            @(negedge clk);
            vld_r = 1'b0;
            check($sformatf("R10 rev mask word%0d", w), 32'(mask_r), 32'(exp_mask(w, 1'b1)));
        end
        check("R10 rev word4 pattern", 32'(exp_mask(4, 1'b1)), 32'hC1);
        check("R10 rev count", 32'(cnt_r), 3);

        summary();
    end

endmodule